// File: doc/BRIEF.md
# Master Clock Rate Conditioner with Word-Clock Alignment

This block sits at the clock input of an audio converter datapath. Its master clock runs at either 256 or 384 times the sample rate, and a static select input says which. From that clock it derives a single enable that pulses at 256 times the sample rate, so all downstream logic runs in one clock domain at one effective rate. At the 384x ratio the enable is suppressed on one master clock in every three, which gives an average rate of 2/3.

The block also keeps a frame position that counts enables modulo 256. It aligns that position to the rising edge of the incoming word clock. The word clock is synchronous to the master clock, but the phase between them is arbitrary. Timing starts on the first word-clock rising edge after reset is released. From then on, each rising edge is compared against the running position. A small error is tolerated. A larger error moves the frame position back onto the edge without any reset, and the locked indication drops until alignment has held for two frames in a row.

The active-low power-down input clears all state asynchronously. Its release is synchronised to the master clock before the logic starts.

Top module: `mck_ratio_conditioner`

## Requirements
- R1: With `ratio_sel_i` = 0 (master clock at 256x), `tick_o` is high on every master clock once the block has left power-down.
- R2: With `ratio_sel_i` = 1 (master clock at 384x), `tick_o` is high on exactly two of every three consecutive master clocks and is never low on two clocks in a row.
- R3: While `rst_n_i` is low, `tick_o`, `frame_o` and `locked_o` are all low, and the frame state is cleared.
- R4: After power-down ends, `frame_o` stays low until a word-clock rising edge is seen. A rising edge is a clock on which `wclk_i` is 1 after being 0 on the previous clock. The first such edge sets the frame position to 0, so `frame_o` fires on the first enable after that clock.
- R5: Once started, the frame position advances by one on each enable and wraps from 255 to 0. `frame_o` is high exactly on an enable whose position is 0, so it fires once every 256 enables.
- R6: A later rising edge is first scored against the position the counter would move to on that clock. If that position lies within ±1 of 0 (255, 0 or 1), the counter is left alone. Otherwise the position is reloaded to 0 and the next enable raises `frame_o`.
- R7: `locked_o` rises on the clock after the second consecutive in-tolerance rising edge that follows the starting edge or a reload. It falls on the clock after an out-of-tolerance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (256x or 384x the sample rate) |
| rst_n_i | input | 1 | Active-low power-down; asynchronous assert, synchronised release |
| ratio_sel_i | input | 1 | Ratio select: 0 = 256x, 1 = 384x |
| wclk_i | input | 1 | Word clock, synchronous to `clk_i`, one period per sample |
| tick_o | output | 1 | Enable at 256 times the sample rate |
| frame_o | output | 1 | One-enable strobe at frame position 0 |
| locked_o | output | 1 | Frame position aligned to the word clock |

## Verification
The assertions assume that `wclk_i` is already in the master-clock domain, that it stays high and low for at least one clock each, and that `ratio_sel_i` only changes while the block is powered down. The stimulus follows these rules. It builds every word-clock period from a whole number of master clocks, and it changes the ratio only inside a power-down interval. Periods of exactly 256 or 384 clocks test aligned operation. Periods lengthened by one clock test the tolerance window, and periods off by ten or thirty clocks force a reload.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;

  // Master clock ratio selected by the ratio pin
  typedef enum logic {
    RATIO_X1   = 1'b0,   // master clock already at 256 fs
    RATIO_X1P5 = 1'b1    // master clock at 384 fs, thin to 2/3
  } ratio_e;

  // How a word-clock rising edge is scored by the frame timer
  typedef enum logic [1:0] {
    EDGE_NONE    = 2'd0,
    EDGE_FIRST   = 2'd1,
    EDGE_ALIGNED = 2'd2,
    EDGE_SLIP    = 2'd3
  } edge_e;

endpackage

// File: rtl/mcc_reset_sync.sv
`timescale 1ns/1ps
module mcc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/mcc_rate_enable.sv
`timescale 1ns/1ps
module mcc_rate_enable
  import mcc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_n_i,
  input  ratio_e ratio_i,
  output logic   tick_o
);

  localparam logic [1:0] PH_LAST = 2'd2;

  logic [1:0] ph_q;
  logic [1:0] ph_d;

  // Three-phase sequencer, parked at phase 0 in the 1x ratio
  always_comb begin
    if (ratio_i == RATIO_X1P5) ph_d = (ph_q == PH_LAST) ? 2'd0 : ph_q + 2'd1;
    else                       ph_d = 2'd0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) ph_q <= 2'd0;
    else          ph_q <= ph_d;
  end

  // Enable is dropped on the last phase when thinning 384 fs to 256 fs
  assign tick_o = rst_n_i && ((ratio_i == RATIO_X1) || (ph_q != PH_LAST));

  // R1
  x1_every_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ratio_i == RATIO_X1) |-> tick_o);

  // R2
  x15_single_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((ratio_i == RATIO_X1P5) && !tick_o) |=> tick_o);

  // R2
  x15_two_then_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((ratio_i == RATIO_X1P5) && tick_o && $past(tick_o)) |=> !tick_o);

endmodule

// File: rtl/mcc_word_edge.sv
`timescale 1ns/1ps
module mcc_word_edge (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic wclk_i,
  output logic rise_o
);

  logic wclk_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) wclk_q <= 1'b0;
    else          wclk_q <= wclk_i;
  end

  assign rise_o = wclk_i && !wclk_q;

endmodule

// File: rtl/mcc_frame_timer.sv
`timescale 1ns/1ps
module mcc_frame_timer
  import mcc_pkg::*;
#(
  parameter int FRAME_TICKS = 256,
  parameter int PHASE_TOL   = 1,
  parameter int LOCK_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic tick_i,
  input  logic rise_i,
  output logic frame_o,
  output logic locked_o
);

  localparam int CNT_W  = $clog2(FRAME_TICKS);
  localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(FRAME_TICKS - 1);
  localparam logic [CNT_W-1:0]  TOL_LO   = CNT_W'(PHASE_TOL);
  localparam logic [CNT_W-1:0]  TOL_HI   = CNT_W'(FRAME_TICKS - PHASE_TOL);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_FRAMES);
  localparam logic [GOOD_W-1:0] GOOD_PRE = GOOD_W'(LOCK_FRAMES - 1);

  logic              started_q, started_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic              locked_q, locked_d;

  logic [CNT_W-1:0]  cnt_adv;
  logic              in_tol;
  edge_e             edge_cls;

  // Position this clock would leave the counter at without any edge
  always_comb begin
    if (tick_i) cnt_adv = (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
    else        cnt_adv = cnt_q;
  end

  assign in_tol = (cnt_adv <= TOL_LO) || (cnt_adv >= TOL_HI);

  always_comb begin
    if (!rise_i)         edge_cls = EDGE_NONE;
    else if (!started_q) edge_cls = EDGE_FIRST;
    else if (in_tol)     edge_cls = EDGE_ALIGNED;
    else                 edge_cls = EDGE_SLIP;
  end

  always_comb begin
    started_d = started_q;
    cnt_d     = cnt_q;
    good_d    = good_q;
    locked_d  = locked_q;
    case (edge_cls)
      EDGE_NONE: begin
        if (started_q) cnt_d = cnt_adv;
      end
      EDGE_FIRST: begin
        started_d = 1'b1;
        cnt_d     = '0;
        good_d    = '0;
        locked_d  = 1'b0;
      end
      EDGE_ALIGNED: begin
        cnt_d  = cnt_adv;
        good_d = (good_q == GOOD_MAX) ? good_q : good_q + GOOD_W'(1);
        if (good_q >= GOOD_PRE) locked_d = 1'b1;
      end
      EDGE_SLIP: begin
        cnt_d    = '0;
        good_d   = '0;
        locked_d = 1'b0;
      end
      default: begin
        cnt_d = cnt_q;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      started_q <= 1'b0;
      cnt_q     <= '0;
      good_q    <= '0;
      locked_q  <= 1'b0;
    end else begin
      started_q <= started_d;
      cnt_q     <= cnt_d;
      good_q    <= good_d;
      locked_q  <= locked_d;
    end
  end

  assign frame_o  = started_q && tick_i && (cnt_q == '0);
  assign locked_o = locked_q;

  // R4
  first_edge_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rise_i && !started_q) |=> (started_q && (cnt_q == '0)));

  // R5
  position_wraps_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (started_q && !rise_i && tick_i && (cnt_q == CNT_LAST)) |=> (cnt_q == '0));

  // R6
  slip_reloads_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (edge_cls == EDGE_SLIP) |=> ((cnt_q == '0) && !locked_q));

  // R7
  lock_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(locked_q) |-> $past(rise_i));

endmodule

// File: rtl/mck_ratio_conditioner.sv
`timescale 1ns/1ps
module mck_ratio_conditioner
  import mcc_pkg::*;
#(
  parameter int FRAME_TICKS = 256,
  parameter int PHASE_TOL   = 1,
  parameter int LOCK_FRAMES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ratio_sel_i,
  input  logic wclk_i,
  output logic tick_o,
  output logic frame_o,
  output logic locked_o
);

  logic   run_n;
  logic   tick;
  logic   rise;
  ratio_e ratio;

  assign ratio = ratio_e'(ratio_sel_i);

  mcc_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i    (clk_i),
    .arst_n_i (rst_n_i),
    .rst_n_o  (run_n)
  );

  mcc_rate_enable u_rate (
    .clk_i   (clk_i),
    .rst_n_i (run_n),
    .ratio_i (ratio),
    .tick_o  (tick)
  );

  mcc_word_edge u_edge (
    .clk_i   (clk_i),
    .rst_n_i (run_n),
    .wclk_i  (wclk_i),
    .rise_o  (rise)
  );

  mcc_frame_timer #(
    .FRAME_TICKS (FRAME_TICKS),
    .PHASE_TOL   (PHASE_TOL),
    .LOCK_FRAMES (LOCK_FRAMES)
  ) u_frame (
    .clk_i    (clk_i),
    .rst_n_i  (run_n),
    .tick_i   (tick),
    .rise_i   (rise),
    .frame_o  (frame_o),
    .locked_o (locked_o)
  );

  assign tick_o = tick;

  // R3
  powerdown_quiet_chk: assert property (@(posedge clk_i)
    !rst_n_i |-> (!tick_o && !frame_o && !locked_o));

endmodule

// File: tb/mck_ratio_conditioner_tb.sv
`timescale 1ns/1ps
module mck_ratio_conditioner_tb;

  localparam int FT = 256;
  localparam real TCLK = 8.0;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ratio_sel = 1'b0;
  logic wclk = 1'b0;
  logic tick, frame, locked;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference model state
  bit m_started;
  int m_pos;
  int m_good;
  bit m_lock;
  bit m_prev_w;
  int idx;
  bit t1, t2;
  int frames_seen;

  always #(TCLK/2) clk = ~clk;

  mck_ratio_conditioner u_dut (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .ratio_sel_i (ratio_sel),
    .wclk_i      (wclk),
    .tick_o      (tick),
    .frame_o     (frame),
    .locked_o    (locked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_started = 0; m_pos = 0; m_good = 0; m_lock = 0; m_prev_w = 0;
    idx = 0; t1 = 0; t2 = 0;
  endtask

  // One master clock: drive wclk, sample outputs, compare, advance model
  task automatic cyc(input bit w);
    bit rise;
    int n;
    int err;
    @(negedge clk);
    wclk = w;
    #1;
    if (ratio_sel == 1'b0 && idx >= 2)
      chk(tick == 1'b1, "R1 tick every clock", tick, 1);
    if (ratio_sel == 1'b1 && idx >= 4)
      chk((int'(tick) + int'(t1) + int'(t2)) == 2, "R2 two of three",
          int'(tick) + int'(t1) + int'(t2), 2);
    chk(frame == (m_started && tick && m_pos == 0), "R5 frame strobe", frame,
        int'(m_started && tick && m_pos == 0));
    chk(locked == m_lock, "R7 locked flag", locked, m_lock);
    if (frame) frames_seen++;
    rise = w && !m_prev_w;
    n = m_started ? (m_pos + int'(tick)) % FT : 0;
    if (rise) begin
      if (!m_started) begin
        m_started = 1; m_pos = 0; m_good = 0; m_lock = 0;
      end else begin
        err = (n >= FT/2) ? n - FT : n;
        if (err >= -1 && err <= 1) begin
          m_pos = n;
          if (m_good < 2) m_good++;
          if (m_good >= 2) m_lock = 1;
        end else begin
          m_pos = 0; m_good = 0; m_lock = 0;
        end
      end
    end else if (m_started) begin
      m_pos = n;
    end
    m_prev_w = w;
    t2 = t1; t1 = tick;
    idx++;
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0;
    wclk = 1'b0;
    ratio_sel = mode;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(!tick && !frame && !locked, "R3 outputs low in power-down",
          {tick, frame, locked}, 0);
      @(negedge clk);
    end
    model_clear();
    rst_n = 1'b1;
    frames_seen = 0;
    for (int i = 0; i < 8; i++) cyc(1'b0);
    chk(frames_seen == 0, "R4 no frame before first edge", frames_seen, 0);
  endtask

  task automatic frame_wave(input int period, input int count);
    for (int f = 0; f < count; f++) begin
      for (int c = 0; c < period; c++) cyc(c < period / 2);
    end
  endtask

  initial begin
    #(TCLK * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    // ---- 256x ratio ----
    do_reset(1'b0);
    frames_seen = 0;
    frame_wave(256, 4);
    chk(frames_seen == 4, "R5 one strobe per 256 enables", frames_seen, 4);
    chk(locked == 1'b1, "R7 locked after two aligned edges", locked, 1);
    // late by one clock, then back: within tolerance
    frame_wave(257, 1);
    frame_wave(255, 1);
    frame_wave(256, 1);
    chk(locked == 1'b1, "R6 one-enable error tolerated", locked, 1);
    // edge ten clocks late: reload
    frame_wave(266, 1);
    frames_seen = 0;
    frame_wave(256, 1);
    chk(locked == 1'b0, "R6 slip clears lock", locked, 0);
    chk(frames_seen == 1, "R6 realigned strobe after slip", frames_seen, 1);
    frame_wave(256, 3);
    chk(locked == 1'b1, "R7 relock after slip", locked, 1);
    // ---- 384x ratio, entered through power-down ----
    do_reset(1'b1);
    frames_seen = 0;
    frame_wave(384, 4);
    chk(frames_seen == 4, "R2 384 clocks hold one frame", frames_seen, 4);
    chk(locked == 1'b1, "R7 locked at 384x", locked, 1);
    frame_wave(385, 1);
    frame_wave(383, 1);
    frame_wave(384, 1);
    chk(locked == 1'b1, "R6 tolerance at 384x", locked, 1);
    frame_wave(414, 1);
    frame_wave(384, 1);
    chk(locked == 1'b0, "R6 slip at 384x", locked, 0);
    frame_wave(384, 3);
    chk(locked == 1'b1, "R7 relock at 384x", locked, 1);
    // power-down in the middle of operation
    do_reset(1'b0);
    chk(locked == 1'b0, "R3 lock cleared by power-down", locked, 0);
    frame_wave(256, 2);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule